// File: doc/BRIEF.md
# Next-PC Unit with Delay-Slot Sequencing

This block holds the program counter of a 32-bit RISC core whose control-flow instructions each have one delay slot. On every cycle in which the core issues an instruction, the unit receives the decoded control class, the 16-bit branch offset, the 26-bit jump index, the destination register field and the two source operand values. It tests the branch condition and forms the branch, jump or register target. It also produces the return address for linking forms. It then holds the redirect until the delay-slot instruction has issued.

The unit also handles two special cases. A branch-likely that is not taken marks its slot instruction as annulled, so the core discards that instruction's results. A register-indirect jump whose target is not word-aligned does not redirect. Instead, one exception pulse with a cause code and the faulting address appears only after the slot instruction has issued. Exception vectoring, the register file and fetch are handled outside the unit.

Top module: `nextpc_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `pc` equals the parameter RESET_VEC (default 32'hBFC00000), and `in_slot`, `annul` and `exc` are low.
- R2: An issued class-0 (sequential) instruction outside a slot advances `pc` by 4 at the next edge. When `issue` is low, `pc` and the slot state hold.
- R3: Conditional classes compare operands as signed 32-bit values. Class 1 branches when rs==rt, 2 when rs!=rt, 3 when rs<=0, 4 when rs>0, 5 and 7 when rs<0, 6 and 8 when rs>=0.
- R4: A taken branch at address P goes to P+4 plus the 16-bit offset shifted left by two and sign-extended to 32 bits.
- R5: Classes 9 and 10 (absolute jumps) at address P go to the top four bits of P+4, followed by the 26-bit index, followed by two zero bits.
- R6: After any non-zero class, the next issued instruction is the delay slot at P+4. While it is waiting, `in_slot` is high. The redirect takes effect at the edge on which the slot issues. A non-zero class presented in the slot neither redirects nor links.
- R7: Classes 7, 8 and 10 drive `link_we` with `link_idx`=31 and `link_val`=P+8 in their issue cycle, whether or not the branch is taken. Class 12 links to the `rd` field and does not link when `rd` is 0.
- R8: With `likely` high on a conditional class (1 to 8), a not-taken branch drives `annul` high throughout its slot cycle. A taken branch leaves `annul` low.
- R9: Classes 11 and 12 (register-indirect) whose rs value has a non-zero low two bits do not redirect. On the cycle after the slot issues, `exc` is high for exactly one cycle with `exc_cause`=4 and `exc_addr` equal to that rs value, and `pc` moves on to P+8.
- R10: An aligned register-indirect target is loaded into `pc` when the slot issues. The low two bits of `pc` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Instruction at `pc` issues this cycle |
| cls | input | 4 | Control class code of the issued instruction |
| likely | input | 1 | Branch-likely variant of a conditional class |
| off | input | 16 | Branch offset in words |
| idx | input | 26 | Absolute jump index in words |
| rd | input | 5 | Link destination for class 12 |
| rs_val | input | 32 | First source operand |
| rt_val | input | 32 | Second source operand |
| pc | output | 32 | Address of the instruction to issue |
| in_slot | output | 1 | Current instruction is a delay slot |
| annul | output | 1 | Current slot instruction is annulled |
| link_we | output | 1 | Return-address write this cycle |
| link_idx | output | 5 | Register receiving the return address |
| link_val | output | 32 | Return address |
| exc | output | 1 | Misaligned-target exception pulse |
| exc_cause | output | 4 | Exception cause code |
| exc_addr | output | 32 | Faulting target address |

## Verification
The bench targets signed comparisons at zero and at the most negative value. A design that compares unsigned values would branch on negative operands in the wrong direction. It also checks offsets with the top bit set: if the offset is not sign-extended, the branch lands about 256 KB forward instead of backward. The jump page is taken from the slot address, and a test across a 256 MB boundary catches a design that uses the branch's own address. Other tests check that a misaligned register jump traps only after its slot issues and never redirects, that an annulled slot is flagged only for likely branches that are not taken, and that a control class placed in a slot causes no second redirect.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

    typedef enum logic [3:0] {
        CF_SEQ    = 4'd0,
        CF_BEQ    = 4'd1,
        CF_BNE    = 4'd2,
        CF_BLEZ   = 4'd3,
        CF_BGTZ   = 4'd4,
        CF_BLTZ   = 4'd5,
        CF_BGEZ   = 4'd6,
        CF_BLTZAL = 4'd7,
        CF_BGEZAL = 4'd8,
        CF_J      = 4'd9,
        CF_JAL    = 4'd10,
        CF_JR     = 4'd11,
        CF_JALR   = 4'd12
    } cf_class_e;

    localparam logic [4:0] RA_REG      = 5'd31;
    localparam logic [3:0] CAUSE_ALIGN = 4'd4;

    typedef struct packed {
        logic        busy;
        logic        redirect;
        logic        kill;
        logic        trap;
        logic [31:0] target;
    } slot_state_t;

    function automatic logic is_cond(input logic [3:0] c);
        return (c >= 4'd1) && (c <= 4'd8);
    endfunction

    function automatic logic is_reg_jump(input logic [3:0] c);
        return (c == CF_JR) || (c == CF_JALR);
    endfunction

    function automatic logic links_ra(input logic [3:0] c);
        return (c == CF_BLTZAL) || (c == CF_BGEZAL) || (c == CF_JAL);
    endfunction

endpackage

// File: rtl/nextpc_cond.sv
module nextpc_cond
    import nextpc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [3:0]      cls,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            taken
);
    logic signed [XLEN-1:0] sa;
    logic                   neg, zero;

    always_comb begin
        sa   = $signed(a);
        neg  = sa < 0;
        zero = (a == '0);
        case (cf_class_e'(cls))
            CF_BEQ:              taken = (a == b);
            CF_BNE:              taken = (a != b);
            CF_BLEZ:             taken = neg || zero;
            CF_BGTZ:             taken = !neg && !zero;
            CF_BLTZ, CF_BLTZAL:  taken = neg;
            CF_BGEZ, CF_BGEZAL:  taken = !neg;
            CF_J, CF_JAL,
            CF_JR, CF_JALR:      taken = 1'b1;
            default:             taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/nextpc_target.sv
module nextpc_target
    import nextpc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int IDX_W = 26
) (
    input  logic [3:0]       cls,
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  rs,
    output logic [XLEN-1:0]  target,
    output logic [XLEN-1:0]  link_addr,
    output logic             misaligned
);
    localparam int EXT_W  = XLEN - OFF_W - 2;
    localparam int PAGE_W = XLEN - IDX_W - 2;

    logic [XLEN-1:0] slot_pc, br_disp, br_tgt, j_tgt;

    always_comb begin
        slot_pc    = pc + XLEN'(4);
        br_disp    = {{EXT_W{off[OFF_W-1]}}, off, 2'b00};
        br_tgt     = slot_pc + br_disp;
        j_tgt      = {slot_pc[XLEN-1 -: PAGE_W], idx, 2'b00};
        link_addr  = pc + XLEN'(8);
        misaligned = is_reg_jump(cls) && (rs[1:0] != 2'b00);
        case (cf_class_e'(cls))
            CF_J, CF_JAL:    target = j_tgt;
            CF_JR, CF_JALR:  target = rs;
            default:         target = br_tgt;
        endcase
    end
endmodule

// File: rtl/nextpc_seq.sv
module nextpc_seq
    import nextpc_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            issue,
    input  logic            start_cf,
    input  logic            taken,
    input  logic            likely_cond,
    input  logic            misaligned,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] pc,
    output logic            in_slot,
    output logic            annul,
    output logic            exc,
    output logic [XLEN-1:0] exc_addr
);
    slot_state_t     st;
    logic [XLEN-1:0] pc_q, bad_q;
    logic            exc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= XLEN'(RESET_VEC);
            st    <= '0;
            exc_q <= 1'b0;
            bad_q <= '0;
        end else begin
            exc_q <= 1'b0;
            if (issue) begin
                if (!st.busy) begin
                    pc_q <= pc_q + XLEN'(4);
                    if (start_cf) begin
                        st.busy     <= 1'b1;
                        st.redirect <= taken && !misaligned;
                        st.kill     <= likely_cond && !taken;
                        st.trap     <= misaligned;
                        st.target   <= 32'(target);
                    end
                end else begin
                    pc_q    <= st.redirect ? XLEN'(st.target) : pc_q + XLEN'(4);
                    exc_q   <= st.trap;
                    if (st.trap) bad_q <= XLEN'(st.target);
                    st.busy <= 1'b0;
                end
            end
        end
    end

    assign pc       = pc_q;
    assign in_slot  = st.busy;
    assign annul    = st.busy && st.kill;
    assign exc      = exc_q;
    assign exc_addr = bad_q;
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter int          XLEN      = 32,
    parameter int          OFF_W     = 16,
    parameter int          IDX_W     = 26,
    parameter logic [31:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  logic [3:0]       cls,
    input  logic             likely,
    input  logic [OFF_W-1:0] off,
    input  logic [IDX_W-1:0] idx,
    input  logic [4:0]       rd,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  rt_val,
    output logic [XLEN-1:0]  pc,
    output logic             in_slot,
    output logic             annul,
    output logic             link_we,
    output logic [4:0]       link_idx,
    output logic [XLEN-1:0]  link_val,
    output logic             exc,
    output logic [3:0]       exc_cause,
    output logic [XLEN-1:0]  exc_addr
);
    logic            taken, misaligned, start_cf, likely_cond;
    logic [XLEN-1:0] target, link_addr;

    nextpc_cond #(.XLEN(XLEN)) u_cond (
        .cls(cls), .a(rs_val), .b(rt_val), .taken(taken)
    );

    nextpc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_tgt (
        .cls(cls), .pc(pc), .off(off), .idx(idx), .rs(rs_val),
        .target(target), .link_addr(link_addr), .misaligned(misaligned)
    );

    assign start_cf    = (cls != CF_SEQ) && (cls <= CF_JALR);
    assign likely_cond = likely && is_cond(cls);

    nextpc_seq #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_seq (
        .clk(clk), .rst(rst), .issue(issue), .start_cf(start_cf),
        .taken(taken), .likely_cond(likely_cond), .misaligned(misaligned),
        .target(target), .pc(pc), .in_slot(in_slot), .annul(annul),
        .exc(exc), .exc_addr(exc_addr)
    );

    always_comb begin
        link_we  = 1'b0;
        link_idx = '0;
        if (issue && !in_slot) begin
            if (links_ra(cls)) begin
                link_we  = 1'b1;
                link_idx = RA_REG;
            end else if (cls == CF_JALR && rd != 5'd0) begin
                link_we  = 1'b1;
                link_idx = rd;
            end
        end
    end

    assign link_val  = link_addr;
    assign exc_cause = exc ? CAUSE_ALIGN : 4'd0;
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        issue,
    input logic [3:0]  cls,
    input logic [31:0] pc,
    input logic        in_slot,
    input logic        annul,
    input logic        exc,
    input logic        link_we,
    input logic [4:0]  link_idx
);
    // R10
    pc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

    // R8
    annul_in_slot_chk: assert property (@(posedge clk) disable iff (rst)
        annul |-> in_slot);

    // R9
    exc_after_slot_chk: assert property (@(posedge clk) disable iff (rst)
        exc |-> $past(in_slot && issue));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && !in_slot && cls == 4'd0) |=> pc == $past(pc) + 32'd4);

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !issue |=> $stable(pc) && $stable(in_slot));

    // R7
    link_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_idx != 5'd0 && !in_slot));

    // R6
    slot_leaves_chk: assert property (@(posedge clk) disable iff (rst)
        (issue && in_slot) |=> !in_slot);
endmodule

bind nextpc_unit nextpc_unit_chk u_chk (
    .clk(clk), .rst(rst), .issue(issue), .cls(cls), .pc(pc),
    .in_slot(in_slot), .annul(annul), .exc(exc),
    .link_we(link_we), .link_idx(link_idx)
);

// File: tb/tb_nextpc_unit.sv
module tb_nextpc_unit;
    localparam logic [31:0] RV = 32'hBFC0_0000;

    logic        clk = 0, rst = 1, issue = 0, likely = 0;
    logic [3:0]  cls = 0;
    logic [15:0] off = 0;
    logic [25:0] idx = 0;
    logic [4:0]  rd = 0;
    logic [31:0] rs_val = 0, rt_val = 0;
    logic [31:0] pc, link_val, exc_addr;
    logic        in_slot, annul, link_we, exc;
    logic [4:0]  link_idx;
    logic [3:0]  exc_cause;

    nextpc_unit dut (.*);

    always #10 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;

    logic [31:0] m_pc, m_tgt, m_bad;
    bit m_busy, m_redir, m_kill, m_trap, m_exc;
    string m_tag;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic bit f_taken(input logic [3:0] c, input logic [31:0] a, input logic [31:0] b);
        case (c)
            1: return a == b;
            2: return a != b;
            3: return $signed(a) <= 0;
            4: return $signed(a) > 0;
            5, 7: return $signed(a) < 0;
            6, 8: return $signed(a) >= 0;
            default: return c >= 9 && c <= 12;
        endcase
    endfunction

    function automatic logic [31:0] f_target(input logic [3:0] c, input logic [31:0] p,
                                             input logic [15:0] o, input logic [25:0] j,
                                             input logic [31:0] a);
        logic [31:0] s = p + 4;
        if (c == 9 || c == 10) return {s[31:28], j, 2'b00};
        if (c == 11 || c == 12) return a;
        return s + {{14{o[15]}}, o, 2'b00};
    endfunction

    task automatic step(input bit iss, input logic [3:0] c, input bit lk,
                        input logic [15:0] o, input logic [25:0] j, input logic [4:0] r,
                        input logic [31:0] a, input logic [31:0] b, input string tag);
        bit exp_we;
        logic [4:0] exp_idx;
        issue = iss; cls = c; likely = lk; off = o; idx = j; rd = r;
        rs_val = a; rt_val = b;
        #5;
        chk(in_slot == m_busy, "R6", "in_slot", 32'(in_slot), 32'(m_busy));
        chk(annul == (m_busy && m_kill), "R8", "annul", 32'(annul), 32'(m_busy && m_kill));
        exp_we = 0; exp_idx = 0;
        if (iss && !m_busy) begin
            if (c == 7 || c == 8 || c == 10) begin exp_we = 1; exp_idx = 31; end
            else if (c == 12 && r != 0) begin exp_we = 1; exp_idx = r; end
        end
        chk(link_we == exp_we, "R7", "link_we", 32'(link_we), 32'(exp_we));
        if (exp_we) begin
            chk(link_idx == exp_idx, "R7", "link_idx", 32'(link_idx), 32'(exp_idx));
            chk(link_val == m_pc + 8, "R7", "link_val", link_val, m_pc + 8);
        end
        m_exc = 0;
        if (iss) begin
            if (!m_busy) begin
                if (c != 0 && c <= 12) begin
                    bit t = f_taken(c, a, b);
                    bit mis = (c == 11 || c == 12) && a[1:0] != 0;
                    m_busy = 1; m_trap = mis; m_redir = t && !mis;
                    m_kill = lk && c <= 8 && !t;
                    m_tgt = f_target(c, m_pc, o, j, a);
                    m_tag = tag;
                end
                m_pc = m_pc + 4;
            end else begin
                m_exc = m_trap;
                if (m_trap) m_bad = m_tgt;
                m_pc = m_redir ? m_tgt : m_pc + 4;
                m_busy = 0;
                tag = m_tag;
            end
        end
        @(posedge clk); #1;
        chk(pc == m_pc, tag, "pc", pc, m_pc);
        chk(pc[1:0] == 2'b00, "R10", "pc low bits", pc, {pc[31:2], 2'b00});
        chk(exc == m_exc, "R9", "exc", 32'(exc), 32'(m_exc));
        if (m_exc) begin
            chk(exc_cause == 4'd4, "R9", "cause", 32'(exc_cause), 32'd4);
            chk(exc_addr == m_bad, "R9", "exc_addr", exc_addr, m_bad);
        end
    endtask

    function automatic string tag_of(input logic [3:0] c, input logic [31:0] a);
        if (c == 0) return "R2";
        if (c <= 8) return "R4";
        if (c <= 10) return "R5";
        return (a[1:0] != 0) ? "R9" : "R10";
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got hang expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        chk(pc == RV, "R1", "pc in reset", pc, RV);
        rst = 0;
        @(posedge clk); #1;
        chk(pc == RV, "R1", "pc after reset", pc, RV);
        chk(!in_slot && !annul && !exc, "R1", "flags after reset",
            {29'd0, in_slot, annul, exc}, 32'd0);
        m_pc = RV; m_busy = 0; m_kill = 0; m_trap = 0; m_redir = 0; m_exc = 0;
        m_tgt = 0; m_bad = 0; m_tag = "R2";

        step(1, 0, 0, 0, 0, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R2");
        // R3 signed compare: negative rs, blez taken, bgtz not
        step(1, 3, 0, 16'hFFFC, 0, 0, 32'h8000_0000, 0, "R3");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
        step(1, 4, 0, 16'h0010, 0, 0, 32'hFFFF_FFFF, 0, "R3");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R3");
        // R8 likely not taken: annulled slot
        step(1, 1, 1, 16'h0020, 0, 0, 5, 6, "R8");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R8");
        // R8 likely taken
        step(1, 1, 1, 16'h0020, 0, 0, 5, 5, "R8");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R6");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R8");
        // R7 BLTZAL not taken still links; R6 control class in slot ignored
        step(1, 7, 0, 16'h0008, 0, 0, 32'd1, 0, "R7");
        step(1, 9, 0, 0, 26'h3FFFFFF, 0, 0, 0, "R6");
        // R9 misaligned JALR with rd=0: no link, deferred trap
        step(1, 12, 0, 0, 0, 0, 32'h1234_5672, 0, "R9");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R2");
        // R10 aligned JALR to rd
        step(1, 12, 0, 0, 0, 5'd7, 32'h0FFF_FFFC, 0, "R10");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R10");
        // R5 jump across a 256 MB page: slot lies in the next page
        step(1, 11, 0, 0, 0, 0, 32'h1FFF_FFFC, 0, "R10");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R10");
        step(1, 10, 0, 0, 26'h0000010, 0, 0, 0, "R5");
        step(1, 0, 0, 0, 0, 0, 0, 0, "R5");

        for (int n = 0; n < 3000; n++) begin
            logic [3:0] c;
            logic [31:0] a, b;
            bit is;
            is = ($urandom % 8) != 0;
            c = ($urandom % 2) ? 4'd0 : 4'(1 + $urandom % 12);
            case ($urandom % 4)
                0: a = 0;
                1: a = 32'(-($urandom % 3));
                2: a = $urandom;
                default: a = $urandom % 4;
            endcase
            b = ($urandom % 2) ? a : $urandom;
            if ((c == 11 || c == 12) && ($urandom % 3) != 0) a[1:0] = 2'b00;
            step(is, c, 1'($urandom), 16'($urandom), 26'($urandom), 5'($urandom),
                 a, b, tag_of(c, a));
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule